// File: doc/BRIEF.md
# Compare-Match Timer with Power-Mode Gating

A 16-bit up-counter that advances on a tick chosen from four sources: three divisions of the system clock and a slow sub-clock that runs asynchronously to the system clock. The sub-clock is brought into the system domain through a synchronizer and then divided by four. A compare register is checked against the counter. A match flag is raised as the counter moves off the matching value, one counter tick after equality first appears. An optional clear-on-match turns the counter into a programmable-period timer. An overflow flag marks the wrap past the top value.

A three-bit power-mode input decides whether the counter runs. In the two full-speed modes it always counts. In the three low-power modes that keep the sub-clock alive it counts only when the sub-clock source is selected. In the two deepest modes it holds. The reset mode forces every register to its reset value. Software reaches the counter, the compare value, the control bits and the status flags through a flat register port, with a combinational read.

Top module: `cm_timer`

## Requirements
- R1: While `pwr_mode_i` is 0 (reset), each clock edge loads the reset values: counter 0x0000, compare 0xFFFF, control 0, both flags 0.
- R2: Control field `sel` (control bits 2:1) picks the tick source. Value 0 gives one tick per 32 system clocks, 1 gives one per 16, 2 gives one per 4, and 3 gives one tick per four rising edges of `sub_clk_i` after a two-stage synchronizer. The system-clock dividers run freely from `rst_ni`.
- R3: The overflow flag (status bit 0) is set when a tick takes the counter from 0xFFFF to 0x0000.
- R4: The match flag (status bit 1) is set by a tick that finds the counter equal to the compare value. Equality alone, with no tick, sets nothing.
- R5: With clear-on-match (control bit 0) set, a matching tick loads 0 into the counter instead of incrementing it, and does not count as an overflow.
- R6: In modes 1 (active) and 2 (sleep), every tick advances the counter.
- R7: In modes 3 (watch), 4 (subactive) and 5 (subsleep), ticks are honoured only when `sel` is 3. Otherwise the counter holds.
- R8: In modes 6 (standby) and 7 (module standby), the counter holds whatever the source, and all registers keep their contents.
- R9: A flag is cleared by writing 0 to its status bit, but only after a read of the status register has returned that flag as 1. A write of 0 without such a read is ignored. A set event in the same cycle as a clearing write wins.
- R10: A counter write in the same cycle as a tick takes priority over the tick. It also suppresses the match detection and the overflow detection for that tick.
- R11: Register map at `addr_i` is 0 counter, 1 compare, 2 control, 3 status. Control and status read back in bits 2:0 and 1:0, with zeros above. `rdata_o` reflects the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sub_clk_i | input | 1 | Slow sub-clock, asynchronous to clk_i |
| pwr_mode_i | input | 3 | Power mode, 0 reset to 7 module standby |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (arms flag clearing) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational |

## Verification
A write, a tick, a mode change or a flag event takes effect in the register state at the next rising edge. A read shows that state through `rdata_o` in the same cycle. The bench drives inputs at the falling edge. A cycle-level reference model updates at each rising edge from the same inputs, and every read is compared just after the falling edge, with no offset to tune. Sub-clock ticks carry a synchronizer delay of two to three system clocks. Those checks let the sub-clock go idle and wait ten cycles before reading the counter, so they compare only settled tick counts.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  typedef enum logic [2:0] {
    PM_RESET    = 3'd0,
    PM_ACTIVE   = 3'd1,
    PM_SLEEP    = 3'd2,
    PM_WATCH    = 3'd3,
    PM_SUBACT   = 3'd4,
    PM_SUBSLEEP = 3'd5,
    PM_STANDBY  = 3'd6,
    PM_MODSTBY  = 3'd7
  } pwr_mode_e;

  localparam int NUM_SRC  = 4;
  localparam int SEL_W    = $clog2(NUM_SRC);
  localparam logic [SEL_W-1:0] SEL_SUB = SEL_W'(NUM_SRC - 1);

  localparam logic [1:0] A_CNT  = 2'd0;
  localparam logic [1:0] A_CMP  = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  localparam int NUM_FLAG = 2;
  localparam int F_OVF    = 0;
  localparam int F_CMF    = 1;

  function automatic logic count_allowed(input logic [2:0] mode, input logic [SEL_W-1:0] sel);
    case (pwr_mode_e'(mode))
      PM_ACTIVE, PM_SLEEP:               return 1'b1;
      PM_WATCH, PM_SUBACT, PM_SUBSLEEP:  return (sel == SEL_SUB);
      default:                           return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int DIV_A_LOG2 = 5,
  parameter int DIV_B_LOG2 = 4,
  parameter int DIV_C_LOG2 = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [2:0] tick_o
);
  localparam int AB_MAX = (DIV_A_LOG2 > DIV_B_LOG2) ? DIV_A_LOG2 : DIV_B_LOG2;
  localparam int PRE_W  = (AB_MAX > DIV_C_LOG2) ? AB_MAX : DIV_C_LOG2;
  localparam int LOG2S [3] = '{DIV_A_LOG2, DIV_B_LOG2, DIV_C_LOG2};

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  for (genvar g = 0; g < 3; g++) begin : g_tap
    assign tick_o[g] = &pre_q[LOG2S[g]-1:0];
  end
endmodule

// File: rtl/cmt_subsync.sv
module cmt_subsync #(
  parameter int SYNC_STAGES  = 2,
  parameter int SUB_DIV_LOG2 = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sub_clk_i,
  output logic tick_o
);
  logic [SYNC_STAGES-1:0]  sync_q;
  logic                    prev_q;
  logic [SUB_DIV_LOG2-1:0] div_q;
  logic                    rise;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sync_q[s] <= 1'b0;
      else if (s == 0) sync_q[s] <= sub_clk_i;
      else             sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  assign rise   = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign tick_o = rise & (&div_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      div_q  <= '0;
    end else begin
      prev_q <= sync_q[SYNC_STAGES-1];
      if (rise) div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/cmt_core.sv
module cmt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_clr_i,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             clr_on_match_i,
  input  logic [CNT_W-1:0] ocr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  // write beats tick and masks its events
  assign step    = tick_i & ~wr_i;
  assign match_o = step & (cnt_q == ocr_i);
  assign wrap_o  = step & (&cnt_q) & ~(match_o & clr_on_match_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (sync_clr_i)                   cnt_q <= '0;
    else if (wr_i)                         cnt_q <= wdata_i;
    else if (match_o && clr_on_match_i)    cnt_q <= '0;
    else if (step)                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cmt_flag.sv
module cmt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_clr_i,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, arm_q, clr_ok;

  assign clr_ok = wr_i & ~wbit_i & arm_q;
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (sync_clr_i) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (set_i)       flag_q <= 1'b1;
      else if (clr_ok) flag_q <= 1'b0;
      if (clr_ok && !set_i)     arm_q <= 1'b0;
      else if (rd_i && flag_q)  arm_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cm_timer.sv
module cm_timer #(
  parameter int CNT_W        = 16,
  parameter int DIV_A_LOG2   = 5,
  parameter int DIV_B_LOG2   = 4,
  parameter int DIV_C_LOG2   = 2,
  parameter int SUB_DIV_LOG2 = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sub_clk_i,
  input  logic [2:0]       pwr_mode_i,
  input  logic [1:0]       addr_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o
);
  import cmt_pkg::*;

  logic [NUM_SRC-1:0]  src_tick;
  logic [SEL_W-1:0]    sel_q;
  logic                clr_q;
  logic [CNT_W-1:0]    ocr_q;
  logic [CNT_W-1:0]    cnt_w;
  logic                pm_rst, run, tick;
  logic                wr_cnt, wr_stat, rd_stat;
  logic                match_w, wrap_w;
  logic [NUM_FLAG-1:0] flag_set, flag_w;

  assign pm_rst  = (pwr_mode_i == PM_RESET);
  assign run     = count_allowed(pwr_mode_i, sel_q);
  assign tick    = run & src_tick[sel_q];
  assign wr_cnt  = wr_en_i & (addr_i == A_CNT);
  assign wr_stat = wr_en_i & (addr_i == A_STAT);
  assign rd_stat = rd_en_i & (addr_i == A_STAT);

  cmt_prescaler #(
    .DIV_A_LOG2(DIV_A_LOG2), .DIV_B_LOG2(DIV_B_LOG2), .DIV_C_LOG2(DIV_C_LOG2)
  ) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(src_tick[2:0])
  );

  cmt_subsync #(
    .SYNC_STAGES(SYNC_STAGES), .SUB_DIV_LOG2(SUB_DIV_LOG2)
  ) u_sub (
    .clk_i(clk_i), .rst_ni(rst_ni), .sub_clk_i(sub_clk_i), .tick_o(src_tick[3])
  );

  cmt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_clr_i(pm_rst), .tick_i(tick),
    .wr_i(wr_cnt), .wdata_i(wdata_i), .clr_on_match_i(clr_q), .ocr_i(ocr_q),
    .cnt_o(cnt_w), .match_o(match_w), .wrap_o(wrap_w)
  );

  assign flag_set[F_OVF] = wrap_w;
  assign flag_set[F_CMF] = match_w;

  for (genvar f = 0; f < NUM_FLAG; f++) begin : g_flag
    cmt_flag u_flag (
      .clk_i(clk_i), .rst_ni(rst_ni), .sync_clr_i(pm_rst), .set_i(flag_set[f]),
      .rd_i(rd_stat), .wr_i(wr_stat), .wbit_i(wdata_i[f]), .flag_o(flag_w[f])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ocr_q <= '1;
      sel_q <= '0;
      clr_q <= 1'b0;
    end else if (pm_rst) begin
      ocr_q <= '1;
      sel_q <= '0;
      clr_q <= 1'b0;
    end else if (wr_en_i) begin
      if (addr_i == A_CMP)  ocr_q <= wdata_i;
      if (addr_i == A_CTRL) {sel_q, clr_q} <= wdata_i[SEL_W:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CNT:   rdata_o = cnt_w;
      A_CMP:   rdata_o = ocr_q;
      A_CTRL:  rdata_o[SEL_W:0] = {sel_q, clr_q};
      default: rdata_o[NUM_FLAG-1:0] = flag_w;
    endcase
  end
endmodule

// File: rtl/cmt_chk.sv
module cmt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       pwr_mode_i,
  input logic             wr_en_i,
  input logic [1:0]       addr_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic [1:0]       sel_q,
  input logic             clr_q,
  input logic [CNT_W-1:0] cnt_w,
  input logic [CNT_W-1:0] ocr_q,
  input logic [1:0]       flag_w,
  input logic             match_w
);
  logic wr_cnt;
  assign wr_cnt = wr_en_i && addr_i == 2'd0;

  assert_rst_values_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_mode_i == 3'd0 |=> cnt_w == '0 && ocr_q == '1 && flag_w == 2'b00 && sel_q == 2'd0 && !clr_q);

  assert_ovf_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_w[0]) |-> $past(cnt_w) == '1);

  assert_match_leave_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_w[1]) |-> $past(cnt_w) == $past(ocr_q) && $past(pwr_mode_i) != 3'd0);

  assert_clear_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_w && clr_q |=> cnt_w == '0);

  assert_watch_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_mode_i inside {3'd3, 3'd4, 3'd5}) && sel_q != 2'd3 && !wr_cnt |=> $stable(cnt_w));

  assert_standby_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_mode_i inside {3'd6, 3'd7}) && !wr_cnt |=> $stable(cnt_w));

  assert_write_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt && pwr_mode_i != 3'd0 |=> cnt_w == $past(wdata_i));
endmodule

bind cm_timer cmt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_mode_i(pwr_mode_i), .wr_en_i(wr_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .sel_q(sel_q), .clr_q(clr_q),
  .cnt_w(cnt_w), .ocr_q(ocr_q), .flag_w(flag_w), .match_w(match_w)
);

// File: tb/cm_timer_tb.sv
module cm_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sub_clk = 1'b0;
  logic [2:0]  mode = 3'd1;
  logic [1:0]  addr = 2'd0;
  logic        we = 1'b0, re = 1'b0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  cm_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sub_clk_i(sub_clk), .pwr_mode_i(mode),
    .addr_i(addr), .wr_en_i(we), .rd_en_i(re), .wdata_i(wdata), .rdata_o(rdata)
  );

  // reference model, built from the requirements
  logic [4:0]  m_pre;
  logic [15:0] m_cnt, m_ocr;
  logic [1:0]  m_sel, m_flag, m_arm;
  logic        m_clr;

  function automatic logic m_src_tick(input logic [1:0] s, input logic [4:0] p);
    case (s)
      2'd0:    return p == 5'd31;
      2'd1:    return p[3:0] == 4'hF;
      2'd2:    return p[1:0] == 2'd3;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = '0; m_cnt = '0; m_ocr = '1; m_sel = '0; m_clr = 0; m_flag = '0; m_arm = '0;
    end else begin
      logic run, step, mt, wr_c;
      logic [1:0] ev;
      run  = (mode == 3'd1 || mode == 3'd2) ||
             ((mode == 3'd3 || mode == 3'd4 || mode == 3'd5) && m_sel == 2'd3);
      wr_c = we && addr == 2'd0;
      step = run && m_src_tick(m_sel, m_pre) && !wr_c;
      m_pre = m_pre + 1'b1;
      if (mode == 3'd0) begin
        m_cnt = '0; m_ocr = '1; m_sel = '0; m_clr = 0; m_flag = '0; m_arm = '0;
      end else begin
        mt = step && m_cnt == m_ocr;
        ev[1] = mt;
        ev[0] = step && m_cnt == 16'hFFFF && !(mt && m_clr);
        for (int f = 0; f < 2; f++) begin
          logic clr_ok;
          clr_ok = we && addr == 2'd3 && !wdata[f] && m_arm[f];
          if (clr_ok && !ev[f]) m_arm[f] = 0;
          else if (re && addr == 2'd3 && m_flag[f]) m_arm[f] = 1;
          if (ev[f]) m_flag[f] = 1;
          else if (clr_ok) m_flag[f] = 0;
        end
        if (wr_c)            m_cnt = wdata;
        else if (mt && m_clr) m_cnt = '0;
        else if (step)       m_cnt = m_cnt + 1'b1;
        if (we && addr == 2'd1) m_ocr = wdata;
        if (we && addr == 2'd2) {m_sel, m_clr} = wdata[2:0];
      end
    end
  end

  function automatic logic [15:0] m_rd(input logic [1:0] a);
    case (a)
      2'd0:    return m_cnt;
      2'd1:    return m_ocr;
      2'd2:    return {13'd0, m_sel, m_clr};
      default: return {14'd0, m_flag};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    re = 1; addr = a;
    #1 chk(tag, rdata, m_rd(a));
    @(negedge clk);
    re = 0;
  endtask

  task automatic rd_exp(input logic [1:0] a, input logic [15:0] e, input string tag);
    re = 1; addr = a;
    #1 chk(tag, rdata, e);
    @(negedge clk);
    re = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sub_periods(input int n);
    for (int i = 0; i < n; i++) begin
      sub_clk = 1; idle(6);
      sub_clk = 0; idle(6);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle(3);
    rst_n = 1;
    idle(2);
    // R1 reset values
    for (int a = 0; a < 4; a++) rd(2'(a), "R1");

    // R6/R2 active, each divider
    for (int s = 0; s < 3; s++) begin
      wr(2'd2, 16'(s << 1));
      wr(2'd0, 16'h0000);
      idle(100);
      rd(2'd0, "R2");
      rd(2'd2, "R11");
    end
    mode = 3'd2; idle(37); rd(2'd0, "R6");

    // R3 overflow and R9 clear protocol
    mode = 3'd1;
    wr(2'd2, 16'h0004);
    wr(2'd0, 16'hFFF0);
    idle(100);
    rd(2'd0, "R3");
    wr(2'd3, 16'h0000);           // no prior read: ignored
    addr = 2'd3; #1 chk("R9", rdata & 16'h1, 16'h1);
    rd(2'd3, "R3");
    wr(2'd3, 16'h0000);
    rd(2'd3, "R9");

    // R4 equality without tick sets nothing
    mode = 3'd6;
    wr(2'd1, 16'h0040);
    wr(2'd0, 16'h0040);
    idle(20);
    rd(2'd3, "R4");
    chk("R4", rdata & 16'h2, 16'h0);
    mode = 3'd1; idle(10);
    rd(2'd3, "R4");
    chk("R4", rdata & 16'h2, 16'h2);
    wr(2'd3, 16'h0000);
    rd(2'd3, "R9");

    // R5 clear on match
    wr(2'd1, 16'h0005);
    wr(2'd2, 16'h0005);
    wr(2'd0, 16'h0000);
    for (int i = 0; i < 10; i++) begin idle(7); rd(2'd0, "R5"); end
    rd(2'd3, "R5");

    // R7 watch with a system-clock source holds
    mode = 3'd3; wr(2'd2, 16'h0004); wr(2'd0, 16'h0123);
    idle(60); rd(2'd0, "R7");
    chk("R7", rdata, 16'h0123);

    // R10 writes on every cycle mask match and overflow
    mode = 3'd1;
    rd(2'd3, "R10"); wr(2'd3, 16'h0000);
    wr(2'd1, 16'hFFFF);
    for (int i = 0; i < 12; i++) wr(2'd0, 16'hFFFF);
    wr(2'd0, 16'h0000);
    rd(2'd3, "R10");
    chk("R10", rdata, 16'h0000);

    // R2/R7/R8 sub-clock source
    wr(2'd2, 16'h0006);
    mode = 3'd3;
    wr(2'd0, 16'h0000);
    sub_periods(40); idle(10);
    rd_exp(2'd0, 16'd10, "R2");
    mode = 3'd6;
    sub_periods(20); idle(10);
    rd_exp(2'd0, 16'd10, "R8");
    rd(2'd1, "R8");
    mode = 3'd4;
    sub_periods(20); idle(10);
    rd_exp(2'd0, 16'd15, "R7");
    mode = 3'd1;
    wr(2'd2, 16'h0004);
    wr(2'd0, 16'h0000);
    rd(2'd0, "R11");

    // constrained random against the model
    for (int it = 0; it < 3000; it++) begin
      int op;
      op = $urandom_range(0, 99);
      if (op < 35) idle($urandom_range(1, 6));
      else if (op < 60) rd(2'($urandom_range(0, 3)), "R11");
      else if (op < 85) begin
        int a;
        a = $urandom_range(0, 3);
        case (a)
          0: wr(2'd0, ($urandom_range(0, 1) != 0) ? 16'($urandom_range(0, 63)) : 16'hFFF0 + 16'($urandom_range(0, 15)));
          1: wr(2'd1, ($urandom_range(0, 3) != 0) ? 16'($urandom_range(0, 63)) : 16'hFFFF);
          2: wr(2'd2, 16'(($urandom_range(0, 2) << 1) | $urandom_range(0, 1)));
          default: wr(2'd3, 16'($urandom_range(0, 3)));
        endcase
      end else if (op < 98) mode = 3'($urandom_range(1, 7));
      else begin
        mode = 3'd0; idle(1); rd(2'd1, "R1"); mode = 3'd1;
      end
    end
    for (int a = 0; a < 4; a++) rd(2'(a), "R11");
    finish_run();
  end
endmodule